// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

This block is the control unit of a small 8-bit accumulator machine built around one shared data bus. It is a Moore state machine. Each instruction is fetched in two clocked steps: the program counter is sent to the address register, then memory is loaded into the instruction register while the program counter advances. One decode cycle follows. In that cycle the upper nibble of the instruction register, which is now valid, chooses a fixed chain of micro-steps for the opcode. In each state the sequencer drives a set of control strobes. These enable one bus driver and one or more loads, the RAM write, the ALU subtract mode, the program-counter count and load, the output-register load and the halt flag.

The datapath is outside the block. The registers, RAM and ALU sit around it and obey the strobes. The only thing the sequencer reads back is the opcode nibble. There are no condition flags, so a jump is always taken.

Top module: `acc_seq_ctrl`

## Requirements
- R1: The 4-bit `opcode` input carries the upper nibble of the instruction register. The codes are 0001 load-from-memory, 0010 add, 0011 subtract, 0100 store, 0101 load-immediate, 0110 jump, 1110 output, 1111 halt and 0000 no-op. All other codes are unused.
- R2: While `rst` is high, and in the first cycle after it falls, every strobe is 0. The next cycle asserts only `pc_drv` and `mar_load`.
- R3: The second fetch cycle asserts only `ram_drv`, `ir_load` and `pc_inc`. It is followed by one decode cycle with all strobes 0. The opcode is sampled in that decode cycle.
- R4: Load-from-memory asserts `ir_drv`+`mar_load`, then `ram_drv`+`a_load`, then returns to the first fetch cycle.
- R5: Add asserts `ir_drv`+`mar_load`, then `ram_drv`+`b_load`, then `alu_drv`+`a_load`.
- R6: Subtract follows the add chain, and `alu_sub` is high only in its last step, together with `alu_drv`+`a_load`.
- R7: Store asserts `ir_drv`+`mar_load`, then `a_drv`+`ram_wr`.
- R8: Load-immediate asserts `ir_drv`+`a_load` in one step.
- R9: Jump asserts `ir_drv`+`pc_load`, then spends one cycle with all strobes 0 before the next fetch.
- R10: Output asserts `a_drv`+`out_load` in one step.
- R11: Halt asserts `halt` alone. This state is held, with no other strobe, until `rst`.
- R12: No-op and the unused codes return to the first fetch cycle straight after the decode cycle.
- R13: At most one of `a_drv`, `b_drv`, `ir_drv`, `ram_drv`, `alu_drv`, `pc_drv` is high in any cycle. Every strobe not listed for a step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Upper nibble of the instruction register |
| a_drv | output | 1 | Accumulator drives the bus |
| a_load | output | 1 | Accumulator loads from the bus |
| b_drv | output | 1 | B register drives the bus |
| b_load | output | 1 | B register loads from the bus |
| ir_drv | output | 1 | Instruction low nibble drives the bus |
| ir_load | output | 1 | Instruction register loads from the bus |
| mar_load | output | 1 | Memory address register loads from the bus |
| ram_drv | output | 1 | RAM drives the bus |
| ram_wr | output | 1 | RAM writes the bus value |
| alu_drv | output | 1 | ALU result drives the bus |
| alu_sub | output | 1 | ALU subtracts instead of adding |
| pc_drv | output | 1 | Program counter drives the bus |
| pc_load | output | 1 | Program counter loads from the bus |
| pc_inc | output | 1 | Program counter increments |
| out_load | output | 1 | Output register loads from the bus |
| halt | output | 1 | Machine halted |

## Verification
The bench attaches a small model of the registers and RAM to the strobes, so that the strobes execute real programs. A directed program checks every step of every chain cycle by cycle. If decode used the stale opcode during the second fetch cycle, the store and the output would act on the previous instruction and the cycle check would catch the shifted chain. If the jump lost its idle cycle, or if subtract raised `alu_sub` early, that cycle would no longer match. Random straight-line programs with forward jumps and unused codes are compared against an instruction-level interpreter. A halt that leaked strobes, or a no-op that fell into another chain, would change the output values, the accumulator or the stored data.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP  = 4'b0000,
        OPC_LDM  = 4'b0001,
        OPC_ADD  = 4'b0010,
        OPC_SUB  = 4'b0011,
        OPC_STM  = 4'b0100,
        OPC_LDI  = 4'b0101,
        OPC_JMP  = 4'b0110,
        OPC_OUT  = 4'b1110,
        OPC_HALT = 4'b1111
    } opc_e;

    typedef enum logic [4:0] {
        ST_INIT,
        ST_FETCH_ADDR,
        ST_FETCH_IR,
        ST_DECODE,
        ST_LDM_ADDR,
        ST_LDM_MEM,
        ST_ADD_ADDR,
        ST_ADD_MEM,
        ST_ADD_ALU,
        ST_SUB_ADDR,
        ST_SUB_MEM,
        ST_SUB_ALU,
        ST_STM_ADDR,
        ST_STM_WR,
        ST_LDI_IMM,
        ST_JMP_LOAD,
        ST_JMP_IDLE,
        ST_OUT_LOAD,
        ST_HALTED
    } seq_st_e;

    typedef struct packed {
        logic a_drv;
        logic a_load;
        logic b_drv;
        logic b_load;
        logic ir_drv;
        logic ir_load;
        logic mar_load;
        logic ram_drv;
        logic ram_wr;
        logic alu_drv;
        logic alu_sub;
        logic pc_drv;
        logic pc_load;
        logic pc_inc;
        logic out_load;
        logic halt;
    } ctl_t;

endpackage

// File: rtl/acc_seq_next.sv
module acc_seq_next
    import acc_seq_pkg::*;
(
    input  seq_st_e          cur_st,
    input  logic [OP_W-1:0]  opcode,
    output seq_st_e          nxt_st
);

    seq_st_e dec_st;

    // Opcode dispatch, used only from the decode cycle (R1, R12)
    always_comb begin
        case (opcode)
            OPC_LDM:  dec_st = ST_LDM_ADDR;
            OPC_ADD:  dec_st = ST_ADD_ADDR;
            OPC_SUB:  dec_st = ST_SUB_ADDR;
            OPC_STM:  dec_st = ST_STM_ADDR;
            OPC_LDI:  dec_st = ST_LDI_IMM;
            OPC_JMP:  dec_st = ST_JMP_LOAD;
            OPC_OUT:  dec_st = ST_OUT_LOAD;
            OPC_HALT: dec_st = ST_HALTED;
            default:  dec_st = ST_FETCH_ADDR;
        endcase
    end

    always_comb begin
        case (cur_st)
            ST_INIT:       nxt_st = ST_FETCH_ADDR;
            ST_FETCH_ADDR: nxt_st = ST_FETCH_IR;
            ST_FETCH_IR:   nxt_st = ST_DECODE;
            ST_DECODE:     nxt_st = dec_st;
            ST_LDM_ADDR:   nxt_st = ST_LDM_MEM;
            ST_ADD_ADDR:   nxt_st = ST_ADD_MEM;
            ST_ADD_MEM:    nxt_st = ST_ADD_ALU;
            ST_SUB_ADDR:   nxt_st = ST_SUB_MEM;
            ST_SUB_MEM:    nxt_st = ST_SUB_ALU;
            ST_STM_ADDR:   nxt_st = ST_STM_WR;
            ST_JMP_LOAD:   nxt_st = ST_JMP_IDLE;
            ST_HALTED:     nxt_st = ST_HALTED;
            default:       nxt_st = ST_FETCH_ADDR;
        endcase
    end

endmodule

// File: rtl/acc_seq_strobes.sv
module acc_seq_strobes
    import acc_seq_pkg::*;
(
    input  seq_st_e cur_st,
    output ctl_t    ctl
);

    always_comb begin
        ctl = '0;
        case (cur_st)
            ST_FETCH_ADDR: begin
                ctl.pc_drv   = 1'b1;
                ctl.mar_load = 1'b1;
            end
            ST_FETCH_IR: begin
                ctl.ram_drv = 1'b1;
                ctl.ir_load = 1'b1;
                ctl.pc_inc  = 1'b1;
            end
            ST_LDM_ADDR, ST_ADD_ADDR, ST_SUB_ADDR, ST_STM_ADDR: begin
                ctl.ir_drv   = 1'b1;
                ctl.mar_load = 1'b1;
            end
            ST_LDM_MEM: begin
                ctl.ram_drv = 1'b1;
                ctl.a_load  = 1'b1;
            end
            ST_ADD_MEM, ST_SUB_MEM: begin
                ctl.ram_drv = 1'b1;
                ctl.b_load  = 1'b1;
            end
            ST_ADD_ALU: begin
                ctl.alu_drv = 1'b1;
                ctl.a_load  = 1'b1;
            end
            ST_SUB_ALU: begin
                ctl.alu_drv = 1'b1;
                ctl.alu_sub = 1'b1;
                ctl.a_load  = 1'b1;
            end
            ST_STM_WR: begin
                ctl.a_drv  = 1'b1;
                ctl.ram_wr = 1'b1;
            end
            ST_LDI_IMM: begin
                ctl.ir_drv = 1'b1;
                ctl.a_load = 1'b1;
            end
            ST_JMP_LOAD: begin
                ctl.ir_drv  = 1'b1;
                ctl.pc_load = 1'b1;
            end
            ST_OUT_LOAD: begin
                ctl.a_drv    = 1'b1;
                ctl.out_load = 1'b1;
            end
            ST_HALTED: ctl.halt = 1'b1;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            a_drv,
    output logic            a_load,
    output logic            b_drv,
    output logic            b_load,
    output logic            ir_drv,
    output logic            ir_load,
    output logic            mar_load,
    output logic            ram_drv,
    output logic            ram_wr,
    output logic            alu_drv,
    output logic            alu_sub,
    output logic            pc_drv,
    output logic            pc_load,
    output logic            pc_inc,
    output logic            out_load,
    output logic            halt
);

    typedef struct packed {
        seq_st_e st;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    seq_st_e  nxt_st;
    ctl_t     ctl;

    acc_seq_next u_next (
        .cur_st (seq_q.st),
        .opcode (opcode),
        .nxt_st (nxt_st)
    );

    acc_seq_strobes u_strobes (
        .cur_st (seq_q.st),
        .ctl    (ctl)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.st = nxt_st;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: ST_INIT};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign a_drv    = ctl.a_drv;
    assign a_load   = ctl.a_load;
    assign b_drv    = ctl.b_drv;
    assign b_load   = ctl.b_load;
    assign ir_drv   = ctl.ir_drv;
    assign ir_load  = ctl.ir_load;
    assign mar_load = ctl.mar_load;
    assign ram_drv  = ctl.ram_drv;
    assign ram_wr   = ctl.ram_wr;
    assign alu_drv  = ctl.alu_drv;
    assign alu_sub  = ctl.alu_sub;
    assign pc_drv   = ctl.pc_drv;
    assign pc_load  = ctl.pc_load;
    assign pc_inc   = ctl.pc_inc;
    assign out_load = ctl.out_load;
    assign halt     = ctl.halt;

    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_drv && mar_load) |=> (ram_drv && ir_load && pc_inc));

    assert_decode_gap_R3: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (ctl == '0));

    assert_mem_after_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (ram_drv || ram_wr) |-> $past(mar_load));

    assert_sub_last_R6: assert property (@(posedge clk) disable iff (rst)
        alu_sub |-> (alu_drv && a_load && $past(b_load)));

    assert_jump_idle_R9: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (ctl == '0));

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
        halt |=> (halt && ($countones(ctl) == 1)));

    assert_single_driver_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_drv, b_drv, ir_drv, ram_drv, alu_drv, pc_drv}));

endmodule

// File: tb/test_acc_seq_ctrl.sv
`timescale 1ns/1ps
module test_acc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode;
    logic a_drv, a_load, b_drv, b_load, ir_drv, ir_load, mar_load, ram_drv;
    logic ram_wr, alu_drv, alu_sub, pc_drv, pc_load, pc_inc, out_load, halt;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    acc_seq_ctrl i_acc_seq_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode),
        .a_drv(a_drv), .a_load(a_load), .b_drv(b_drv), .b_load(b_load),
        .ir_drv(ir_drv), .ir_load(ir_load), .mar_load(mar_load),
        .ram_drv(ram_drv), .ram_wr(ram_wr), .alu_drv(alu_drv),
        .alu_sub(alu_sub), .pc_drv(pc_drv), .pc_load(pc_load),
        .pc_inc(pc_inc), .out_load(out_load), .halt(halt)
    );

    // Strobe vector, bit 15 down to bit 0
    localparam logic [15:0] F_A_DRV = 16'h8000, F_A_LD = 16'h4000;
    localparam logic [15:0] F_B_DRV = 16'h2000, F_B_LD = 16'h1000;
    localparam logic [15:0] F_IR_DRV = 16'h0800, F_IR_LD = 16'h0400;
    localparam logic [15:0] F_MAR_LD = 16'h0200, F_RAM_DRV = 16'h0100;
    localparam logic [15:0] F_RAM_WR = 16'h0080, F_ALU_DRV = 16'h0040;
    localparam logic [15:0] F_ALU_SUB = 16'h0020, F_PC_DRV = 16'h0010;
    localparam logic [15:0] F_PC_LD = 16'h0008, F_PC_INC = 16'h0004;
    localparam logic [15:0] F_OUT_LD = 16'h0002, F_HALT = 16'h0001;

    wire [15:0] vec = {a_drv, a_load, b_drv, b_load, ir_drv, ir_load, mar_load,
                       ram_drv, ram_wr, alu_drv, alu_sub, pc_drv, pc_load,
                       pc_inc, out_load, halt};

    // Datapath model driven by the strobes
    logic [7:0] mem [16];
    logic [3:0] pc, mar;
    logic [7:0] ir, acc, breg, outr, bus;

    assign opcode = ir[7:4];

    always_comb begin
        bus = 8'h00;
        if (pc_drv)  bus = {4'h0, pc};
        if (ir_drv)  bus = {4'h0, ir[3:0]};
        if (ram_drv) bus = mem[mar];
        if (a_drv)   bus = acc;
        if (b_drv)   bus = breg;
        if (alu_drv) bus = alu_sub ? (acc - breg) : (acc + breg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0; mar <= '0; ir <= '0; acc <= '0; breg <= '0; outr <= '0;
        end else begin
            if (mar_load) mar <= bus[3:0];
            if (ir_load)  ir <= bus;
            if (a_load)   acc <= bus;
            if (b_load)   breg <= bus;
            if (out_load) outr <= bus;
            if (ram_wr)   mem[mar] <= bus;
            if (pc_load)       pc <= bus[3:0];
            else if (pc_inc)   pc <= pc + 4'd1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R13: bus drivers one-hot or none, every cycle out of reset
    always @(negedge clk) begin
        if (!rst)
            chk($countones({a_drv, b_drv, ir_drv, ram_drv, alu_drv, pc_drv}) <= 1,
                "R13 single driver", vec, 0);
    end

    function automatic int chain_len(input logic [3:0] op);
        case (op)
            4'b0001, 4'b0100, 4'b0110: return 5;
            4'b0010, 4'b0011:          return 6;
            4'b0101, 4'b1110, 4'b1111: return 4;
            default:                   return 3;
        endcase
    endfunction

    function automatic logic [15:0] exp_flags(input logic [3:0] op, input int k);
        if (k == 0) return F_PC_DRV | F_MAR_LD;
        if (k == 1) return F_RAM_DRV | F_IR_LD | F_PC_INC;
        if (k == 2) return 16'h0;
        case (op)
            4'b0001: return (k == 3) ? (F_IR_DRV | F_MAR_LD) : (F_RAM_DRV | F_A_LD);
            4'b0010, 4'b0011: begin
                if (k == 3) return F_IR_DRV | F_MAR_LD;
                if (k == 4) return F_RAM_DRV | F_B_LD;
                return F_ALU_DRV | F_A_LD | ((op == 4'b0011) ? F_ALU_SUB : 16'h0);
            end
            4'b0100: return (k == 3) ? (F_IR_DRV | F_MAR_LD) : (F_A_DRV | F_RAM_WR);
            4'b0101: return F_IR_DRV | F_A_LD;
            4'b0110: return (k == 3) ? (F_IR_DRV | F_PC_LD) : 16'h0;
            4'b1110: return F_A_DRV | F_OUT_LD;
            4'b1111: return F_HALT;
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, input int k);
        if (k < 2) return "R2/R3 fetch";
        if (k == 2) return "R3 decode";
        case (op)
            4'b0001: return "R4 load";
            4'b0010: return "R5 add";
            4'b0011: return "R6 sub";
            4'b0100: return "R7 store";
            4'b0101: return "R8 load-imm";
            4'b0110: return "R9 jump";
            4'b1110: return "R10 output";
            4'b1111: return "R11 halt";
            default: return "R12 nop";
        endcase
    endfunction

    // Reference interpreter (instruction level)
    logic [7:0] rmem [16];
    logic [7:0] racc;
    logic [7:0] rout [16];
    int         rnout;

    task automatic ref_exec();
        logic [3:0] rpc = 4'd0;
        racc = 8'h00; rnout = 0;
        for (int i = 0; i < 16; i++) rmem[i] = mem[i];
        for (int s = 0; s < 40; s++) begin
            logic [7:0] ins = rmem[rpc];
            rpc = rpc + 4'd1;
            case (ins[7:4])
                4'b0001: racc = rmem[ins[3:0]];
                4'b0010: racc = racc + rmem[ins[3:0]];
                4'b0011: racc = racc - rmem[ins[3:0]];
                4'b0100: rmem[ins[3:0]] = racc;
                4'b0101: racc = {4'h0, ins[3:0]};
                4'b0110: rpc = ins[3:0];
                4'b1110: begin rout[rnout] = racc; rnout++; end
                4'b1111: break;
                default: ;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(vec == 16'h0, "R2 strobes in reset", vec, 0);
        rst = 1'b0;
        chk(vec == 16'h0, "R2 initial state", vec, 0);
    endtask

    task automatic run_chain(input logic [3:0] op);
        for (int k = 0; k < chain_len(op); k++) begin
            @(negedge clk);
            chk(vec == exp_flags(op, k), req_of(op, k), vec, exp_flags(op, k));
        end
    endtask

    localparam logic [3:0] DIR_OPS [11] = '{4'h5, 4'h2, 4'h3, 4'h4, 4'h5, 4'h1,
                                            4'hE, 4'h6, 4'h0, 4'h7, 4'hF};

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;

        // Directed program: every chain in sequence
        mem[0] = 8'h55; mem[1] = 8'h2E; mem[2] = 8'h3F; mem[3] = 8'h4D;
        mem[4] = 8'h50; mem[5] = 8'h1D; mem[6] = 8'hE0; mem[7] = 8'h69;
        mem[8] = 8'h51; mem[9] = 8'h00; mem[10] = 8'h70; mem[11] = 8'hF0;
        mem[13] = 8'h00; mem[14] = 8'h07; mem[15] = 8'h03;
        do_reset();
        foreach (DIR_OPS[i]) run_chain(DIR_OPS[i]);
        for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            chk(vec == F_HALT, "R11 halt held", vec, F_HALT);
        end
        chk(outr == 8'd9, "R10 output value", outr, 9);
        chk(mem[13] == 8'd9, "R7 stored value", mem[13], 9);
        chk(acc == 8'd9, "R9 jump skipped load-imm", acc, 9);

        // Random programs against the interpreter
        for (int p = 0; p < 40; p++) begin
            int nout;
            logic [7:0] got [16];
            bit halted;
            for (int a = 0; a < 10; a++) begin
                int sel = $urandom_range(0, 10);
                logic [3:0] arg = 4'(11 + $urandom_range(0, 4));
                case (sel)
                    0: mem[a] = {4'h1, arg};
                    1, 2: mem[a] = {4'h2, arg};
                    3: mem[a] = {4'h3, arg};
                    4: mem[a] = {4'h4, arg};
                    5: mem[a] = {4'h5, 4'($urandom_range(0, 15))};
                    6, 7: mem[a] = 8'hE0;
                    8: mem[a] = (a <= 8) ? {4'h6, 4'(a + 2)} : 8'h00;
                    9: mem[a] = 8'h00;
                    default: mem[a] = {4'(7 + $urandom_range(0, 6)), 4'h3};
                endcase
            end
            mem[10] = 8'hF0;
            for (int a = 11; a < 16; a++) mem[a] = 8'($urandom_range(0, 255));
            ref_exec();
            do_reset();
            nout = 0; halted = 1'b0;
            for (int c = 0; c < 200 && !halted; c++) begin
                @(negedge clk);
                if (out_load && nout < 16) begin got[nout] = bus; nout++; end
                if (halt) halted = 1'b1;
            end
            chk(halted, "R11 reaches halt", halted, 1);
            repeat (3) @(negedge clk);
            chk(vec == F_HALT, "R11 halt hold random", vec, F_HALT);
            chk(nout == rnout, "R10 output count", nout, rnout);
            for (int i = 0; i < nout && i < rnout; i++)
                chk(got[i] == rout[i], "R5/R6/R10 output value", got[i], rout[i]);
            chk(acc == racc, "R4/R8/R12 final accumulator", acc, racc);
            for (int a = 11; a < 16; a++)
                chk(mem[a] == rmem[a], "R7 data memory", mem[a], rmem[a]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule